// File: doc/BRIEF.md
# BCD Countdown Seconds Timer

This block is a register-mapped countdown timer. Its remaining time is held as four packed BCD digits, two for minutes and two for seconds, and it counts down by one second each time a one-hertz strobe arrives. Software loads a start value with a single-cycle register write, and the countdown runs from that value. The current value can be read back at any time.

When the count reaches zero, the timer drives a one-clock interrupt request to an external interrupt controller and then stays at zero until it is written again. The count is never converted to binary. Each decrement walks a borrow chain across the digits. The seconds field reloads to 59 when it borrows, so a written value of 0x0130 expires after ninety ticks.

Top module: `bcd_countdown_timer`

## Requirements
- R1: After reset, the read value is 0x00000000 and irq_o is low.
- R2: A write loads wr_data_i[15:0] into the count. The field layout is bits [3:0] seconds units, [7:4] seconds tens, [11:8] minutes units and [15:12] minutes tens. A read returns that layout with bits above 15 at zero, even when the written upper bits were set.
- R3: Each tick with a nonzero count and no write subtracts one second. A digit that is at 0 when it must borrow becomes 9 and passes the borrow upward (0x0010 becomes 0x0009).
- R4: When the seconds field borrows from 00, it becomes 59 and the minutes field decrements (0x0100 becomes 0x0059, 0x1000 becomes 0x0959).
- R5: With no tick and no write, the count holds its value.
- R6: At 0x0000 the count stays at zero on further ticks and does not wrap. No further interrupt is raised.
- R7: On the tick that takes the count to zero, irq_o is high for exactly one clock. It rises in the same clock as the read value becomes zero.
- R8: Writing zero stops the timer without raising irq_o.
- R9: When a write and a tick occur in the same cycle, the written value is loaded and the tick is dropped.
- R10: A nibble above 9 is stored exactly as written. The first decrement that reaches that digit sets it to 9 (0x000C becomes 0x0009, and 0x00A0 becomes 0x0099).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second strobe, one clock wide |
| wr_en_i | input | 1 | Register write enable |
| wr_data_i | input | 32 | Write data; the low 16 bits are the BCD start value |
| rd_data_o | output | 32 | Current BCD count, zero-extended |
| irq_o | output | 1 | One-clock expiry interrupt request |

## Verification
The bench targets the borrow boundaries:
- units 0 to 9, where a wrong design would show a hex value such as 0x000F;
- seconds 00 to 59, where a design that reloaded 99 would lengthen each minute;
- the minutes tens borrow.

Around expiry, it checks that the interrupt is a single clock aligned with the zero count. A design that raises it level-sensitively, or that wraps to 99:59, fails here. It also checks that writing zero and a write colliding with a tick raise no interrupt and keep the written value. Non-BCD nibbles are checked for being stored as written and then clamped to 9, rather than decremented into hex.

// File: rtl/bcd_tmr_pkg.sv
package bcd_tmr_pkg;
  localparam int unsigned DIGIT_W      = 4;
  localparam int unsigned SEC_TENS_IDX = 1;

  // value a digit takes when it borrows from zero
  function automatic int unsigned reload_of(int unsigned idx);
    return (idx == SEC_TENS_IDX) ? 5 : 9;
  endfunction
endpackage

// File: rtl/bcd_tmr_digit.sv
module bcd_tmr_digit #(
  parameter int unsigned W      = 4,
  parameter int unsigned RELOAD = 9
) (
  input  logic [W-1:0] val_i,
  input  logic         borrow_i,
  output logic [W-1:0] val_o,
  output logic         borrow_o
);
  localparam logic [W-1:0] MAX_BCD  = W'(9);
  localparam logic [W-1:0] RELOAD_V = W'(RELOAD);

  always_comb begin
    val_o    = val_i;
    borrow_o = 1'b0;
    if (borrow_i) begin
      if (val_i == '0) begin
        val_o    = RELOAD_V;
        borrow_o = 1'b1;
      end else if (val_i > MAX_BCD) begin
        val_o = MAX_BCD;  // recover from non-BCD load
      end else begin
        val_o = val_i - W'(1);
      end
    end
  end
endmodule

// File: rtl/bcd_tmr_irq.sv
module bcd_tmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= fire_i;
  end

  p_irq_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: rtl/bcd_countdown_timer.sv
module bcd_countdown_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIGITS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  import bcd_tmr_pkg::*;

  localparam int unsigned CNT_W = DIGITS * DIGIT_W;

  logic [CNT_W-1:0] cnt_q, cnt_dec;
  logic [DIGITS:0]  borrow;
  logic             dec_en, expire;

  assign borrow[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcd_tmr_digit #(
      .W      (DIGIT_W),
      .RELOAD (reload_of(g))
    ) u_digit (
      .val_i    (cnt_q[g*DIGIT_W +: DIGIT_W]),
      .borrow_i (borrow[g]),
      .val_o    (cnt_dec[g*DIGIT_W +: DIGIT_W]),
      .borrow_o (borrow[g+1])
    );
  end

  assign dec_en = tick_i && !wr_en_i && (cnt_q != '0);
  assign expire = dec_en && (cnt_dec == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_en_i) cnt_q <= wr_data_i[CNT_W-1:0];
    else if (dec_en)  cnt_q <= cnt_dec;
  end

  bcd_tmr_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (expire),
    .irq_o  (irq_o)
  );

  assign rd_data_o = DATA_W'(cnt_q);

  logic unused_bits;
  assign unused_bits = ^{wr_data_i[DATA_W-1:CNT_W], borrow[DIGITS]};

  p_write_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> cnt_q == $past(wr_data_i[CNT_W-1:0]));
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !tick_i) |=> $stable(cnt_q));
  p_stop_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && cnt_q == '0) |=> cnt_q == '0);
  p_irq_at_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cnt_q == '0);
  p_irq_from_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i && !wr_en_i));
endmodule

// File: tb/bcd_countdown_timer_tb.sv
module bcd_countdown_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  bcd_countdown_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr),
    .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq)
  );

  // behavioural reference: minutes and seconds as integers
  logic [15:0] exp_cnt;
  logic        exp_irq;
  bit          model_on = 1'b1;

  function automatic logic [15:0] sub_sec(logic [15:0] v);
    int s, m, t;
    s = v[3:0] + 10 * v[7:4];
    m = v[11:8] + 10 * v[15:12];
    t = m * 60 + s - 1;
    m = t / 60; s = t % 60;
    return {4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_cnt <= '0; exp_irq <= 1'b0;
    end else if (wr) begin
      exp_cnt <= wdata[15:0]; exp_irq <= 1'b0;
    end else if (tick && exp_cnt != 0) begin
      exp_cnt <= sub_sec(exp_cnt);
      exp_irq <= (sub_sec(exp_cnt) == 0);
    end else begin
      exp_irq <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      total++;
      if (rdata !== {16'h0, exp_cnt} || irq !== exp_irq) begin
        bad++;
        $display("FAIL R3 model: rd=%h irq=%b exp rd=%h irq=%b",
                 rdata, irq, {16'h0, exp_cnt}, exp_irq);
      end
    end
  end

  task automatic check(string req, logic [31:0] ev, logic ei);
    total++;
    if (rdata !== ev || irq !== ei) begin
      bad++;
      $display("FAIL %s: rd=%h irq=%b exp rd=%h irq=%b", req, rdata, irq, ev, ei);
    end
  endtask

  task automatic cyc(logic w, logic [31:0] d, logic t);
    wr = w; wdata = d; tick = t;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog: rd=%h irq=%b exp done", rdata, irq);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'h0, 1'b0);

    cyc(1, 32'hFFFF_0130, 0);
    check("R2 upper bits zero", 32'h0000_0130, 1'b0);
    cyc(0, 0, 1);
    check("R3 units decrement", 32'h0129, 1'b0);
    cyc(1, 32'h0010, 0); cyc(0, 0, 1);
    check("R3 units borrow", 32'h0009, 1'b0);
    cyc(1, 32'h0100, 0); cyc(0, 0, 1);
    check("R4 seconds to 59", 32'h0059, 1'b0);
    cyc(1, 32'h1000, 0); cyc(0, 0, 1);
    check("R4 minutes tens borrow", 32'h0959, 1'b0);
    repeat (5) cyc(0, 0, 0);
    check("R5 hold without tick", 32'h0959, 1'b0);

    cyc(1, 32'h0002, 0); cyc(0, 0, 1);
    check("R7 one left", 32'h0001, 1'b0);
    cyc(0, 0, 1);
    check("R7 irq at zero", 32'h0000, 1'b1);
    cyc(0, 0, 0);
    check("R7 irq one clock", 32'h0000, 1'b0);
    repeat (3) begin
      cyc(0, 0, 1);
      check("R6 stays zero", 32'h0000, 1'b0);
    end

    cyc(1, 32'h0005, 0); cyc(0, 0, 1);
    cyc(1, 32'h0000, 0);
    check("R8 write zero", 32'h0, 1'b0);
    cyc(0, 0, 1);
    check("R8 no irq later", 32'h0, 1'b0);

    cyc(1, 32'h0001, 0);
    cyc(1, 32'h0042, 1);
    check("R9 write beats tick", 32'h0042, 1'b0);
    cyc(1, 32'h0000, 1);
    check("R9 zero write with tick no irq", 32'h0, 1'b0);

    // run a longer stretch, compared by the model each clock
    cyc(1, 32'h0203, 0);
    for (int i = 0; i < 130; i++) begin
      cyc(0, 0, 1);
      cyc(0, 0, 0);
    end
    check("R6 long run ends at zero", 32'h0, 1'b0);

    model_on = 1'b0;
    cyc(1, 32'h000C, 0);
    check("R10 non-BCD stored", 32'h000C, 1'b0);
    cyc(0, 0, 1);
    check("R10 units clamp", 32'h0009, 1'b0);
    cyc(1, 32'h00A0, 0); cyc(0, 0, 1);
    check("R10 tens clamp", 32'h0099, 1'b0);
    cyc(0, 0, 1);
    check("R10 recovers", 32'h0098, 1'b0);
    cyc(1, 32'h0010, 0);
    model_on = 1'b1;
    cyc(0, 0, 1);
    check("R3 after recovery", 32'h0009, 1'b0);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule